// File: doc/BRIEF.md
# Miss Request Holding Registers

This block keeps track of outstanding instruction-cache line misses. It holds two separate pools of tracking entries: a small pool for demand fetch misses and a larger pool for prefetch misses. Each entry records only a line address and a way mask. The line data that returns from the next cache level goes into a single buffer outside this block, and that buffer is shared by all entries.

Requests arrive on two independent ready/valid ports, one per pool. An incoming address is compared against every live entry in both pools. A repeat of an address that is already tracked is absorbed: the handshake completes and nothing is stored. A new address takes the lowest-numbered free entry of its own pool, and in the same cycle the block emits a way-mask write towards the replacement-policy unit.

The pending entries are exposed to an external arbiter. When the arbiter issues an entry, it marks that entry as issued so it is not picked twice. When the refill of an entry completes, a release strobe with the entry index frees it and shows the entry's contents on a read-out port. A flush empties the fetch pool in one cycle and leaves the prefetch pool untouched.

Top module: `miss_hold_regs`

## Requirements
- R1: After reset, no entry in either pool is valid or pending, and both request ports are ready when no flush is applied.
- R2: A fetch request can occupy only one of the 4 fetch entries, and a prefetch request can occupy only one of the 10 prefetch entries. A port's ready is low only when its own pool is full and the request is not a duplicate. The fetch port is also low during a flush.
- R3: A stored request goes into the lowest-indexed free entry of its pool. From the next cycle that entry is valid and pending, and its address appears in slice [i*ADDR_W +: ADDR_W] of the pool's entry-address output.
- R4: A request whose address equals the address of any valid entry in either pool, as held before the clock edge, completes its handshake with ready high, even when its pool is full. It stores nothing and produces no replacement write. Issued entries still count for this comparison.
- R5: When a fetch request is stored in a cycle, a prefetch request in the same cycle with the same address is treated as a duplicate.
- R6: In the cycle a request is stored, the pool's replacement-write valid is high and carries the request's way mask and address. The replacement-write valid is low in every other cycle.
- R7: An issue strobe names a pool (0 = fetch, 1 = prefetch) and an index. If the named entry is valid, the strobe sets its issued flag, so from the next cycle the entry is no longer pending but is still valid. A strobe that names an invalid entry or an index beyond the pool has no effect.
- R8: A release strobe names a pool (0 = fetch, 1 = prefetch) and an index. In the same cycle, the read-out port shows that entry's address and way mask. From the next cycle the entry is invalid. A release takes precedence over an issue to the same entry.
- R9: A flush invalidates every fetch entry from the next cycle. Prefetch entries are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empties the fetch pool |
| f_req_valid | input | 1 | Fetch miss request valid |
| f_req_ready | output | 1 | Fetch miss request ready |
| f_req_addr | input | ADDR_W | Fetch miss line address |
| f_req_way | input | WAY_N | Fetch miss way mask |
| p_req_valid | input | 1 | Prefetch miss request valid |
| p_req_ready | output | 1 | Prefetch miss request ready |
| p_req_addr | input | ADDR_W | Prefetch miss line address |
| p_req_way | input | WAY_N | Prefetch miss way mask |
| repl_f_valid | output | 1 | Replacement write for a stored fetch request |
| repl_f_addr | output | ADDR_W | Its line address |
| repl_f_way | output | WAY_N | Its way mask |
| repl_p_valid | output | 1 | Replacement write for a stored prefetch request |
| repl_p_addr | output | ADDR_W | Its line address |
| repl_p_way | output | WAY_N | Its way mask |
| f_valid_o | output | FETCH_N | Valid flag of each fetch entry |
| f_pend_o | output | FETCH_N | Valid and not yet issued fetch entries |
| f_ent_addr | output | FETCH_N*ADDR_W | Fetch entry addresses, entry i at [i*ADDR_W +: ADDR_W] |
| p_valid_o | output | PREF_N | Valid flag of each prefetch entry |
| p_pend_o | output | PREF_N | Valid and not yet issued prefetch entries |
| p_ent_addr | output | PREF_N*ADDR_W | Prefetch entry addresses, entry i at [i*ADDR_W +: ADDR_W] |
| iss_valid | input | 1 | Issue strobe |
| iss_pool | input | 1 | Pool of the issued entry, 0 fetch, 1 prefetch |
| iss_idx | input | SEL_W | Index of the issued entry |
| rel_valid | input | 1 | Release strobe |
| rel_pool | input | 1 | Pool of the released entry, 0 fetch, 1 prefetch |
| rel_idx | input | SEL_W | Index of the released entry |
| rel_addr | output | ADDR_W | Address of the entry named by the release inputs |
| rel_way | output | WAY_N | Way mask of the entry named by the release inputs |

## Verification
The bench goes after the points where the pool logic can fail quietly:
- **Duplicate against a full pool.** A design that gated ready on fullness alone would stall here and deadlock the requester.
- **Duplicate against an issued entry or against the other pool.** A design that got this wrong would track the same line twice and refill it twice.
- **Same-cycle fetch and prefetch of one address.** Comparing only against stored entries would allocate in both pools.
- **Reuse of a freed middle entry.** This exposes an allocator that is not lowest-index-first.
- **Out-of-range issue indices.** A design that truncates the index would corrupt an existing fetch entry.
- **Release and issue on one entry in the same cycle.** A wrong precedence would leave a ghost entry.
- **Flush.** A flush that reached the prefetch pool would lose prefetches.

A long pseudo-random sweep over a 16-address space repeats all of these corner cases against an arithmetic model kept in the bench.

// File: rtl/mhr_pkg.sv
// Package mhr_pkg
// Shared types for the miss request holding registers.
// Assumes: single clock domain; pool select is a one-bit code.
package mhr_pkg;

    // Pool selector used on the issue and release strobes.
    typedef enum logic {
        POOL_FETCH = 1'b0,
        POOL_PREF  = 1'b1
    } pool_e;

endpackage

// File: rtl/mhr_pick.sv
// Module mhr_pick
// Lowest-index-first picker: reports whether any bit of vec is set and
// the index of the lowest set bit.
// Assumes: IW is wide enough to hold N-1.
module mhr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan from the top so that the lowest set bit is the last one written.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/mhr_pool.sv
// Module mhr_pool
// One pool of miss tracking entries: address and way mask per entry, a
// valid flag and an issued flag. Allocates the lowest free entry, compares
// two addresses against the live entries, and serves an indexed read-out.
// Assumes: alloc_en is asserted only when full is low; indices are SW bits
// wide and values at or above N never match an entry.
module mhr_pool #(
    parameter int N  = 4,
    parameter int AW = 26,
    parameter int WW = 4,
    parameter int SW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_all,
    input  logic            alloc_en,
    input  logic [AW-1:0]   alloc_addr,
    input  logic [WW-1:0]   alloc_way,
    input  logic            iss_en,
    input  logic [SW-1:0]   iss_idx,
    input  logic            rel_en,
    input  logic [SW-1:0]   rel_idx,
    input  logic [AW-1:0]   cmp_a,
    input  logic [AW-1:0]   cmp_b,
    output logic            hit_a,
    output logic            hit_b,
    output logic            full,
    output logic [N-1:0]    vld,
    output logic [N-1:0]    pend,
    output logic [N*AW-1:0] ent_addr,
    output logic [AW-1:0]   rd_addr,
    output logic [WW-1:0]   rd_way
);

    logic [N-1:0]  vld_q;
    logic [N-1:0]  iss_q;
    logic [AW-1:0] addr_q [N];
    logic [WW-1:0] way_q  [N];
    logic          free_found;
    logic [SW-1:0] free_idx;

    mhr_pick #(.N(N), .IW(SW)) u_free (
        .vec   (~vld_q),
        .found (free_found),
        .idx   (free_idx)
    );

    assign full = ~free_found;
    assign vld  = vld_q;
    assign pend = vld_q & ~iss_q;

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic sel_alloc;
        logic sel_rel;
        logic sel_iss;

        assign sel_alloc = alloc_en && (free_idx == SW'(i)) && !vld_q[i];
        assign sel_rel   = rel_en && (rel_idx == SW'(i));
        assign sel_iss   = iss_en && (iss_idx == SW'(i)) && vld_q[i];

        // Entry state: flush or release clear, then allocation, then issue.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[i] <= 1'b0;
                iss_q[i] <= 1'b0;
            end else if (clr_all || sel_rel) begin
                vld_q[i] <= 1'b0;
                iss_q[i] <= 1'b0;
            end else if (sel_alloc) begin
                vld_q[i] <= 1'b1;
                iss_q[i] <= 1'b0;
            end else if (sel_iss) begin
                iss_q[i] <= 1'b1;
            end
        end

        // Entry payload: captured on allocation, cleared on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q[i] <= '0;
                way_q[i]  <= '0;
            end else if (sel_alloc) begin
                addr_q[i] <= alloc_addr;
                way_q[i]  <= alloc_way;
            end
        end

        assign ent_addr[i*AW +: AW] = addr_q[i];
    end

    // Compare both probe addresses against every live entry.
    always_comb begin
        hit_a = 1'b0;
        hit_b = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (vld_q[i] && addr_q[i] == cmp_a) hit_a = 1'b1;
            if (vld_q[i] && addr_q[i] == cmp_b) hit_b = 1'b1;
        end
    end

    // Indexed read-out of one entry's payload.
    always_comb begin
        rd_addr = '0;
        rd_way  = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_idx_match(i)) begin
                rd_addr = addr_q[i];
                rd_way  = way_q[i];
            end
        end
    end

    function automatic logic rd_idx_match(input int i);
        return rel_idx == SW'(i);
    endfunction

endmodule

// File: rtl/miss_hold_regs.sv
// Module miss_hold_regs
// Miss request holding registers for an instruction cache: a fetch pool and
// a prefetch pool, duplicate filtering across both, replacement way-mask
// writes on each stored request, and issue/release/flush control.
// Assumes: the arbiter issues and releases by pool and index; line data is
// kept outside this block.
module miss_hold_regs
    import mhr_pkg::*;
#(
    parameter int FETCH_N = 4,
    parameter int PREF_N  = 10,
    parameter int ADDR_W  = 26,
    parameter int WAY_N   = 4,
    localparam int MAX_N  = (FETCH_N > PREF_N) ? FETCH_N : PREF_N,
    localparam int SEL_W  = $clog2(MAX_N)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      f_req_valid,
    output logic                      f_req_ready,
    input  logic [ADDR_W-1:0]         f_req_addr,
    input  logic [WAY_N-1:0]          f_req_way,
    input  logic                      p_req_valid,
    output logic                      p_req_ready,
    input  logic [ADDR_W-1:0]         p_req_addr,
    input  logic [WAY_N-1:0]          p_req_way,
    output logic                      repl_f_valid,
    output logic [ADDR_W-1:0]         repl_f_addr,
    output logic [WAY_N-1:0]          repl_f_way,
    output logic                      repl_p_valid,
    output logic [ADDR_W-1:0]         repl_p_addr,
    output logic [WAY_N-1:0]          repl_p_way,
    output logic [FETCH_N-1:0]        f_valid_o,
    output logic [FETCH_N-1:0]        f_pend_o,
    output logic [FETCH_N*ADDR_W-1:0] f_ent_addr,
    output logic [PREF_N-1:0]         p_valid_o,
    output logic [PREF_N-1:0]         p_pend_o,
    output logic [PREF_N*ADDR_W-1:0]  p_ent_addr,
    input  logic                      iss_valid,
    input  logic                      iss_pool,
    input  logic [SEL_W-1:0]          iss_idx,
    input  logic                      rel_valid,
    input  logic                      rel_pool,
    input  logic [SEL_W-1:0]          rel_idx,
    output logic [ADDR_W-1:0]         rel_addr,
    output logic [WAY_N-1:0]          rel_way
);

    logic              f_full, p_full;
    logic              ff_hit_f, ff_hit_p, pf_hit_f, pf_hit_p;
    logic              f_dup, p_dup, f_store, p_store;
    logic              f_iss, p_iss, f_rel, p_rel;
    logic [ADDR_W-1:0] f_rd_addr, p_rd_addr;
    logic [WAY_N-1:0]  f_rd_way, p_rd_way;

    // Strobe decode by pool.
    assign f_iss = iss_valid && (pool_e'(iss_pool) == POOL_FETCH);
    assign p_iss = iss_valid && (pool_e'(iss_pool) == POOL_PREF);
    assign f_rel = rel_valid && (pool_e'(rel_pool) == POOL_FETCH);
    assign p_rel = rel_valid && (pool_e'(rel_pool) == POOL_PREF);

    // Enqueue decision: duplicates are absorbed, full pools stall.
    always_comb begin
        f_dup       = ff_hit_f || pf_hit_f;
        f_req_ready = !flush && (f_dup || !f_full);
        f_store     = f_req_valid && f_req_ready && !f_dup;
        p_dup       = ff_hit_p || pf_hit_p ||
                      (f_store && (f_req_addr == p_req_addr));
        p_req_ready = p_dup || !p_full;
        p_store     = p_req_valid && p_req_ready && !p_dup;
    end

    // Fetch pool: a = fetch request address, b = prefetch request address.
    mhr_pool #(.N(FETCH_N), .AW(ADDR_W), .WW(WAY_N), .SW(SEL_W)) u_fpool (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_all    (flush),
        .alloc_en   (f_store),
        .alloc_addr (f_req_addr),
        .alloc_way  (f_req_way),
        .iss_en     (f_iss),
        .iss_idx    (iss_idx),
        .rel_en     (f_rel),
        .rel_idx    (rel_idx),
        .cmp_a      (f_req_addr),
        .cmp_b      (p_req_addr),
        .hit_a      (ff_hit_f),
        .hit_b      (ff_hit_p),
        .full       (f_full),
        .vld        (f_valid_o),
        .pend       (f_pend_o),
        .ent_addr   (f_ent_addr),
        .rd_addr    (f_rd_addr),
        .rd_way     (f_rd_way)
    );

    // Prefetch pool: never flushed.
    mhr_pool #(.N(PREF_N), .AW(ADDR_W), .WW(WAY_N), .SW(SEL_W)) u_ppool (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_all    (1'b0),
        .alloc_en   (p_store),
        .alloc_addr (p_req_addr),
        .alloc_way  (p_req_way),
        .iss_en     (p_iss),
        .iss_idx    (iss_idx),
        .rel_en     (p_rel),
        .rel_idx    (rel_idx),
        .cmp_a      (f_req_addr),
        .cmp_b      (p_req_addr),
        .hit_a      (pf_hit_f),
        .hit_b      (pf_hit_p),
        .full       (p_full),
        .vld        (p_valid_o),
        .pend       (p_pend_o),
        .ent_addr   (p_ent_addr),
        .rd_addr    (p_rd_addr),
        .rd_way     (p_rd_way)
    );

    // Replacement way-mask writes follow stored requests.
    assign repl_f_valid = f_store;
    assign repl_f_addr  = f_req_addr;
    assign repl_f_way   = f_req_way;
    assign repl_p_valid = p_store;
    assign repl_p_addr  = p_req_addr;
    assign repl_p_way   = p_req_way;

    // Release read-out selected by pool.
    assign rel_addr = p_rel ? p_rd_addr : f_rd_addr;
    assign rel_way  = p_rel ? p_rd_way  : f_rd_way;

endmodule

// File: rtl/miss_hold_chk.sv
// Module miss_hold_chk
// Property checker for miss_hold_regs, attached through bind.
// Assumes: observes ports only; all properties are disabled in reset.
module miss_hold_chk #(
    parameter int FETCH_N = 4,
    parameter int PREF_N  = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               f_req_valid,
    input logic               f_req_ready,
    input logic               p_req_valid,
    input logic               p_req_ready,
    input logic               repl_f_valid,
    input logic               repl_p_valid,
    input logic               rel_valid,
    input logic [FETCH_N-1:0] f_vld,
    input logic [PREF_N-1:0]  p_vld
);

    // R2
    fetch_stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !f_req_ready) |-> (&f_vld));

    // R2
    pref_stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !p_req_ready |-> (&p_vld));

    // R6
    fetch_repl_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        repl_f_valid |-> (f_req_valid && f_req_ready));

    // R6
    pref_repl_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        repl_p_valid |-> (p_req_valid && p_req_ready));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (f_vld == '0));

    // R9
    flush_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !f_req_ready);

    // R3
    fetch_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (repl_f_valid && !rel_valid) |=>
            (f_vld == ($past(f_vld) | ($past(f_vld) + 1'b1))));

    // R3
    pref_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (repl_p_valid && !rel_valid) |=>
            (p_vld == ($past(p_vld) | ($past(p_vld) + 1'b1))));

endmodule

bind miss_hold_regs miss_hold_chk #(.FETCH_N(FETCH_N), .PREF_N(PREF_N)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .f_req_valid  (f_req_valid),
    .f_req_ready  (f_req_ready),
    .p_req_valid  (p_req_valid),
    .p_req_ready  (p_req_ready),
    .repl_f_valid (repl_f_valid),
    .repl_p_valid (repl_p_valid),
    .rel_valid    (rel_valid),
    .f_vld        (f_valid_o),
    .p_vld        (p_valid_o)
);

// File: tb/sim_miss_hold_regs.sv
// Bench sim_miss_hold_regs: directed corner cases, then a pseudo-random
// sweep, all against an arithmetic model of the two pools.
module sim_miss_hold_regs;

    localparam int FN = 4;
    localparam int PN = 10;
    localparam int AW = 26;
    localparam int WN = 4;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          f_req_valid = 1'b0, p_req_valid = 1'b0;
    logic          f_req_ready, p_req_ready;
    logic [AW-1:0] f_req_addr = '0, p_req_addr = '0;
    logic [WN-1:0] f_req_way = '0, p_req_way = '0;
    logic          repl_f_valid, repl_p_valid;
    logic [AW-1:0] repl_f_addr, repl_p_addr;
    logic [WN-1:0] repl_f_way, repl_p_way;
    logic [FN-1:0] f_valid_o, f_pend_o;
    logic [FN*AW-1:0] f_ent_addr;
    logic [PN-1:0] p_valid_o, p_pend_o;
    logic [PN*AW-1:0] p_ent_addr;
    logic          iss_valid = 1'b0, iss_pool = 1'b0;
    logic [SW-1:0] iss_idx = '0;
    logic          rel_valid = 1'b0, rel_pool = 1'b0;
    logic [SW-1:0] rel_idx = '0;
    logic [AW-1:0] rel_addr;
    logic [WN-1:0] rel_way;

    int n_chk = 0;
    int n_fail = 0;

    // Model state
    logic [FN-1:0] mfv = '0, mfi = '0;
    logic [PN-1:0] mpv = '0, mpi = '0;
    logic [AW-1:0] mfa [FN];
    logic [WN-1:0] mfw [FN];
    logic [AW-1:0] mpa [PN];
    logic [WN-1:0] mpw [PN];

    always #10 clk = ~clk;

    miss_hold_regs u0 (.*);

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One clock cycle: drive, check combinational outputs, advance, check state.
    task automatic cyc(input logic fv, input logic [AW-1:0] fa, input logic [WN-1:0] fw,
                       input logic pv, input logic [AW-1:0] pa, input logic [WN-1:0] pw,
                       input logic fl, input logic iv, input logic ip, input logic [SW-1:0] ii,
                       input logic rv, input logic rp, input logic [SW-1:0] ri,
                       input string tag);
        logic fdup, pdup, fr, pr, fst, pst;
        int   ffree, pfree;
        f_req_valid = fv; f_req_addr = fa; f_req_way = fw;
        p_req_valid = pv; p_req_addr = pa; p_req_way = pw;
        flush = fl;
        iss_valid = iv; iss_pool = ip; iss_idx = ii;
        rel_valid = rv; rel_pool = rp; rel_idx = ri;
        #1;
        fdup = 1'b0; pdup = 1'b0; ffree = -1; pfree = -1;
        for (int i = FN - 1; i >= 0; i--) begin
            if (mfv[i] && mfa[i] == fa) fdup = 1'b1;
            if (mfv[i] && mfa[i] == pa) pdup = 1'b1;
            if (!mfv[i]) ffree = i;
        end
        for (int i = PN - 1; i >= 0; i--) begin
            if (mpv[i] && mpa[i] == fa) fdup = 1'b1;
            if (mpv[i] && mpa[i] == pa) pdup = 1'b1;
            if (!mpv[i]) pfree = i;
        end
        fr  = !fl && (fdup || ffree >= 0);
        fst = fv && fr && !fdup;
        if (fst && fa == pa) pdup = 1'b1;   // R5 same-cycle duplicate
        pr  = pdup || pfree >= 0;
        pst = pv && pr && !pdup;
        chk({tag, "/R2"}, "f_req_ready", 64'(f_req_ready), 64'(fr));
        chk({tag, "/R2"}, "p_req_ready", 64'(p_req_ready), 64'(pr));
        chk({tag, "/R6"}, "repl_f_valid", 64'(repl_f_valid), 64'(fst));
        chk({tag, "/R6"}, "repl_p_valid", 64'(repl_p_valid), 64'(pst));
        if (fst) chk({tag, "/R6"}, "repl_f_way", 64'(repl_f_way), 64'(fw));
        if (pst) chk({tag, "/R6"}, "repl_p_way", 64'(repl_p_way), 64'(pw));
        if (rv && !rp && ri < FN && mfv[ri]) begin
            chk({tag, "/R8"}, "rel_addr", 64'(rel_addr), 64'(mfa[ri]));
            chk({tag, "/R8"}, "rel_way", 64'(rel_way), 64'(mfw[ri]));
        end
        if (rv && rp && ri < PN && mpv[ri]) begin
            chk({tag, "/R8"}, "rel_addr", 64'(rel_addr), 64'(mpa[ri]));
            chk({tag, "/R8"}, "rel_way", 64'(rel_way), 64'(mpw[ri]));
        end
        @(posedge clk);
        for (int i = 0; i < FN; i++) begin
            if (fl || (rv && !rp && ri == i)) begin
                mfv[i] = 1'b0; mfi[i] = 1'b0;
            end else if (fst && i == ffree) begin
                mfv[i] = 1'b1; mfi[i] = 1'b0; mfa[i] = fa; mfw[i] = fw;
            end else if (iv && !ip && ii == i && mfv[i]) begin
                mfi[i] = 1'b1;
            end
        end
        for (int i = 0; i < PN; i++) begin
            if (rv && rp && ri == i) begin
                mpv[i] = 1'b0; mpi[i] = 1'b0;
            end else if (pst && i == pfree) begin
                mpv[i] = 1'b1; mpi[i] = 1'b0; mpa[i] = pa; mpw[i] = pw;
            end else if (iv && ip && ii == i && mpv[i]) begin
                mpi[i] = 1'b1;
            end
        end
        @(negedge clk);
        f_req_valid = 1'b0; p_req_valid = 1'b0; flush = 1'b0;
        iss_valid = 1'b0; rel_valid = 1'b0;
        chk({tag, "/R3"}, "f_valid_o", 64'(f_valid_o), 64'(mfv));
        chk({tag, "/R3"}, "p_valid_o", 64'(p_valid_o), 64'(mpv));
        chk({tag, "/R7"}, "f_pend_o", 64'(f_pend_o), 64'(mfv & ~mfi));
        chk({tag, "/R7"}, "p_pend_o", 64'(p_pend_o), 64'(mpv & ~mpi));
        for (int i = 0; i < FN; i++)
            if (mfv[i]) chk({tag, "/R3"}, "f_ent_addr", 64'(f_ent_addr[i*AW +: AW]), 64'(mfa[i]));
        for (int i = 0; i < PN; i++)
            if (mpv[i]) chk({tag, "/R3"}, "p_ent_addr", 64'(p_ent_addr[i*AW +: AW]), 64'(mpa[i]));
    endtask

    task automatic fet(input logic [AW-1:0] a, input logic [WN-1:0] w, input string tag);
        cyc(1, a, w, 0, '0, '0, 0, 0, 0, '0, 0, 0, '0, tag);
    endtask
    task automatic pre(input logic [AW-1:0] a, input logic [WN-1:0] w, input string tag);
        cyc(0, '0, '0, 1, a, w, 0, 0, 0, '0, 0, 0, '0, tag);
    endtask
    task automatic iss(input logic p, input logic [SW-1:0] i, input string tag);
        cyc(0, '0, '0, 0, '0, '0, 0, 1, p, i, 0, 0, '0, tag);
    endtask
    task automatic rel(input logic p, input logic [SW-1:0] i, input string tag);
        cyc(0, '0, '0, 0, '0, '0, 0, 0, 0, '0, 1, p, i, tag);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "f_valid_o", 64'(f_valid_o), 64'd0);
        chk("R1", "p_valid_o", 64'(p_valid_o), 64'd0);
        chk("R1", "pend", 64'({f_pend_o, p_pend_o}), 64'd0);
        chk("R1", "f_req_ready", 64'(f_req_ready), 64'd1);
        chk("R1", "p_req_ready", 64'(p_req_ready), 64'd1);
        @(negedge clk);

        // R2/R3 fill the fetch pool, then a new address stalls
        for (int i = 0; i < FN; i++) fet(AW'(32'h100 + i), WN'(1 << (i % WN)), "R3_fill");
        fet(AW'(32'h200), 4'h1, "R2_full");
        // R4 duplicate of a fetch entry on both ports while fetch pool full
        fet(AW'(32'h102), 4'h2, "R4_dupfull");
        pre(AW'(32'h101), 4'h2, "R4_xpool");
        // R2 fill the prefetch pool, stall, duplicate while full
        for (int i = 0; i < PN; i++) pre(AW'(32'h300 + i), WN'(i), "R3_pfill");
        pre(AW'(32'h400), 4'h3, "R2_pfull");
        pre(AW'(32'h305), 4'h3, "R4_pdupfull");
        // R7 issue, including out-of-range and invalid targets
        iss(0, 4'd1, "R7_f");
        iss(1, 4'd9, "R7_p");
        iss(0, 4'd7, "R7_range");
        iss(1, 4'd12, "R7_range");
        fet(AW'(32'h101), 4'h4, "R4_issued");
        // R8 release a middle entry, then R3 reuse of the freed index
        rel(0, 4'd2, "R8_f");
        rel(1, 4'd0, "R8_p");
        fet(AW'(32'h500), 4'h8, "R3_reuse");
        pre(AW'(32'h600), 4'h5, "R3_preuse");
        // R8 release and issue to one entry in the same cycle
        cyc(0, '0, '0, 0, '0, '0, 0, 1, 0, 4'd3, 1, 0, 4'd3, "R8_reliss");
        rel(1, 4'd4, "R8_p2");
        // R5 fetch and prefetch of one new address in the same cycle
        cyc(1, AW'(32'h777), 4'h3, 1, AW'(32'h777), 4'h6, 0, 0, 0, '0, 0, 0, '0, "R5_same");
        // R9 flush with a fetch request pending, prefetch pool kept
        cyc(1, AW'(32'h888), 4'h1, 0, '0, '0, 1, 0, 0, '0, 0, 0, '0, "R9_flush");
        fet(AW'(32'h888), 4'h1, "R9_after");

        // Sweep over a 16-address space with all strobes mixed
        lf = 32'hACE1_2468;
        for (int n = 0; n < 3000; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            cyc(lf[0], AW'(lf[4:1]), lf[8:5], lf[9], AW'(lf[13:10]), lf[17:14],
                lf[22:18] == 5'd0, lf[23], lf[24], lf[28:25],
                lf[29] | lf[2], lf[30], {lf[31], lf[11], lf[6], lf[3]}, "SWEEP");
        end
        finish_run();
    end

endmodule